// File: doc/BRIEF.md
# Temperature Sensor Poll Sequencer

The block reads a two-byte temperature word from a sensor on a two-wire serial bus, over and over. It does not drive the bus wires. It issues byte-level commands to a separate bus master engine and waits for each one to finish. The commands are START, WRITE of one byte, READ of one byte with an ACK or NACK choice, and STOP. The engine answers each command with a one-cycle done pulse. For writes, that pulse carries the acknowledge bit. For reads, it carries the received byte.

Each poll runs as one fixed transaction:

1. START.
2. The device address for writing, then pointer byte 0x00, which selects the temperature register.
3. A repeated START, with no STOP before it.
4. The device address for reading.
5. Two byte reads, high byte first. The first read is ACKed and the second is NACKed.
6. STOP.

The block then publishes three results together with a one-cycle valid strobe:

- the raw 16-bit word;
- the whole-degree byte;
- a half-degree flag.

If any address or pointer byte is not acknowledged, the block issues STOP at once, pulses an error flag and drops the poll. After each STOP, a programmable idle interval passes before the next poll begins.

Top module: `temp_poll_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd_valid`, `res_valid` and `bus_err` are 0, and `raw_word`, `deg_int` and `half_deg` are 0. The first command issued after reset is START.
- R2: A successful poll issues exactly this command sequence, using op codes START=0, WRITE=1, READ=2, STOP=3:
  - START
  - WRITE 0x90
  - WRITE 0x00
  - START
  - WRITE 0x91
  - READ
  - READ
  - STOP

  The read address 0x91 is the 7-bit address 0x48 with the direction bit set to 1.
- R3: The first READ of a poll is issued with `cmd_rd_ack`=1 and the second with `cmd_rd_ack`=0.
- R4: After a successful poll, `raw_word` equals {first byte read, second byte read}.
- R5: After a successful poll, `deg_int` equals the first byte read and `half_deg` equals bit 7 of the second byte. Bits 6:0 of the second byte have no effect on these two outputs.
- R6: `res_valid` is high for exactly one cycle per successful poll. `raw_word`, `deg_int` and `half_deg` change only together with that pulse.
- R7: If any WRITE is answered with `rsp_ack`=0:
  - the next command is STOP;
  - `bus_err` pulses for exactly one cycle;
  - no `res_valid` pulse occurs;
  - the result outputs keep their previous values.
- R8: Between the cycle in which a STOP is answered and the next START, `cmd_valid` is low for exactly `poll_gap`+1 cycles. `poll_gap` is the value present in the cycle the STOP is answered.
- R9: While `cmd_valid` is high and no `rsp_done` has arrived, `cmd_op`, `cmd_wdata` and `cmd_rd_ack` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_gap | input | GAP_W | Idle cycles between polls, minus one |
| cmd_valid | output | 1 | A command is pending at the bus engine |
| cmd_op | output | 2 | Command op code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_rd_ack | output | 1 | For READ: 1 sends ACK, 0 sends NACK |
| rsp_done | input | 1 | One-cycle pulse when the pending command is finished |
| rsp_ack | input | 1 | For WRITE: 1 means the byte was acknowledged |
| rsp_rdata | input | 8 | Byte received by READ, valid with `rsp_done` |
| raw_word | output | 16 | Last good reading, {high, low} |
| deg_int | output | 8 | Whole-degree part of the last reading |
| half_deg | output | 1 | Half-degree flag of the last reading |
| res_valid | output | 1 | One-cycle pulse when new results are published |
| bus_err | output | 1 | One-cycle pulse on an unacknowledged write |

## Verification
A wrong sequencer state appears at the command port within one response. It shows as a missing repeated START, a stray STOP, a wrong address byte or a swapped ACK choice, and it is visible before the poll ends. A corrupted high-byte latch or formatter shows at the result port in the cycle `res_valid` rises. A fault in the idle timer shows as a gap one or more cycles off, measured from the STOP response to the next START. An error path that fails to abort shows as a further command, or as a valid pulse, where a STOP and a single error pulse were expected.

// File: rtl/temp_poll_pkg.sv
package temp_poll_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_WAIT   = 4'd0,
    ST_START1 = 4'd1,
    ST_WADDR  = 4'd2,
    ST_WPTR   = 4'd3,
    ST_START2 = 4'd4,
    ST_RADDR  = 4'd5,
    ST_RDHI   = 4'd6,
    ST_RDLO   = 4'd7,
    ST_STOP   = 4'd8
  } seq_state_e;

endpackage

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] gap,
  input  logic             run,
  output logic             expired
);

  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en  = load | (run & (cnt_q != '0));
  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)        cnt_d = gap;
    else if (cnt_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/poll_seq_fsm.sv
module poll_seq_fsm
  import temp_poll_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] REG_PTR  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gap_expired,
  input  logic       rsp_done,
  input  logic       rsp_ack,
  output logic       cmd_valid,
  output logic [1:0] cmd_op,
  output logic [7:0] cmd_wdata,
  output logic       cmd_rd_ack,
  output logic       gap_load,
  output logic       gap_run,
  output logic       cap_hi,
  output logic       publish,
  output logic       bus_err
);

  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [7:0] ADDR_RD = {DEV_ADDR, 1'b1};

  seq_state_e state_q, state_d;
  logic       err_d, err_q;
  logic       wr_nack;
  bus_op_e    op;

  assign wr_nack = rsp_done & ~rsp_ack &
                   ((state_q == ST_WADDR) | (state_q == ST_WPTR) | (state_q == ST_RADDR));

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    if (wr_nack) begin
      state_d = ST_STOP;
      err_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_WAIT:   if (gap_expired) state_d = ST_START1;
        ST_START1: if (rsp_done)    state_d = ST_WADDR;
        ST_WADDR:  if (rsp_done)    state_d = ST_WPTR;
        ST_WPTR:   if (rsp_done)    state_d = ST_START2;
        ST_START2: if (rsp_done)    state_d = ST_RADDR;
        ST_RADDR:  if (rsp_done)    state_d = ST_RDHI;
        ST_RDHI:   if (rsp_done)    state_d = ST_RDLO;
        ST_RDLO:   if (rsp_done)    state_d = ST_STOP;
        ST_STOP:   if (rsp_done)    state_d = ST_WAIT;
        default:                    state_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    op         = OP_START;
    cmd_wdata  = 8'h00;
    cmd_rd_ack = 1'b0;
    unique case (state_q)
      ST_WADDR: begin op = OP_WRITE; cmd_wdata = ADDR_WR; end
      ST_WPTR:  begin op = OP_WRITE; cmd_wdata = REG_PTR; end
      ST_RADDR: begin op = OP_WRITE; cmd_wdata = ADDR_RD; end
      ST_RDHI:  begin op = OP_READ;  cmd_rd_ack = 1'b1;   end
      ST_RDLO:  op = OP_READ;
      ST_STOP:  op = OP_STOP;
      default:  op = OP_START;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_valid = (state_q != ST_WAIT);
  assign gap_run   = (state_q == ST_WAIT);
  assign gap_load  = rsp_done & (state_q == ST_STOP);
  assign cap_hi    = rsp_done & (state_q == ST_RDHI);
  assign publish   = rsp_done & (state_q == ST_RDLO);
  assign bus_err   = err_q;

endmodule

// File: rtl/temp_result_fmt.sv
module temp_result_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_hi,
  input  logic        publish,
  input  logic [7:0]  rdata,
  output logic [15:0] raw_word,
  output logic [7:0]  deg_int,
  output logic        half_deg,
  output logic        res_valid
);

  logic [7:0]  hi_q;
  logic [15:0] raw_q;
  logic [7:0]  deg_q;
  logic        half_q;
  logic        vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      deg_q  <= '0;
      half_q <= 1'b0;
    end else if (publish) begin
      raw_q  <= {hi_q, rdata};
      deg_q  <= hi_q;
      half_q <= rdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= publish;
  end

  assign raw_word  = raw_q;
  assign deg_int   = deg_q;
  assign half_deg  = half_q;
  assign res_valid = vld_q;

endmodule

// File: rtl/temp_poll_seq.sv
module temp_poll_seq #(
  parameter int         GAP_W    = 16,
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter logic [7:0] REG_PTR  = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GAP_W-1:0] poll_gap,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_wdata,
  output logic             cmd_rd_ack,
  input  logic             rsp_done,
  input  logic             rsp_ack,
  input  logic [7:0]       rsp_rdata,
  output logic [15:0]      raw_word,
  output logic [7:0]       deg_int,
  output logic             half_deg,
  output logic             res_valid,
  output logic             bus_err
);

  logic gap_load, gap_run, gap_expired, cap_hi, publish;

  poll_interval_timer #(.GAP_W(GAP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .gap     (poll_gap),
    .run     (gap_run),
    .expired (gap_expired)
  );

  poll_seq_fsm #(.DEV_ADDR(DEV_ADDR), .REG_PTR(REG_PTR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .gap_expired (gap_expired),
    .rsp_done    (rsp_done),
    .rsp_ack     (rsp_ack),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_wdata   (cmd_wdata),
    .cmd_rd_ack  (cmd_rd_ack),
    .gap_load    (gap_load),
    .gap_run     (gap_run),
    .cap_hi      (cap_hi),
    .publish     (publish),
    .bus_err     (bus_err)
  );

  temp_result_fmt u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_hi    (cap_hi),
    .publish   (publish),
    .rdata     (rsp_rdata),
    .raw_word  (raw_word),
    .deg_int   (deg_int),
    .half_deg  (half_deg),
    .res_valid (res_valid)
  );

endmodule

// File: rtl/temp_poll_checker.sv
module temp_poll_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [1:0]  cmd_op,
  input logic [7:0]  cmd_wdata,
  input logic        cmd_rd_ack,
  input logic        rsp_done,
  input logic [15:0] raw_word,
  input logic        res_valid,
  input logic        bus_err
);

  // R6: strobe lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R6: results move only with the strobe
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(raw_word));

  // R7: error pulse coincides with a pending STOP
  p_err_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (cmd_valid && cmd_op == 2'd3));

  // R7: error is a single-cycle pulse
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

  // R3: an ACKed read is followed by the NACKed read
  p_ack_then_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && cmd_rd_ack && rsp_done)
      |=> (cmd_valid && cmd_op == 2'd2 && !cmd_rd_ack));

  // R9: pending command holds until answered
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !rsp_done)
      |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_rd_ack)));

endmodule

bind temp_poll_seq temp_poll_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_wdata  (cmd_wdata),
  .cmd_rd_ack (cmd_rd_ack),
  .rsp_done   (rsp_done),
  .raw_word   (raw_word),
  .res_valid  (res_valid),
  .bus_err    (bus_err)
);

// File: tb/tb_temp_poll_seq.sv
`timescale 1ns/1ps
module tb_temp_poll_seq;

  localparam int GAP_W = 16;

  logic             clk;
  logic             rst_n;
  logic [GAP_W-1:0] poll_gap;
  logic             cmd_valid;
  logic [1:0]       cmd_op;
  logic [7:0]       cmd_wdata;
  logic             cmd_rd_ack;
  logic             rsp_done;
  logic             rsp_ack;
  logic [7:0]       rsp_rdata;
  logic [15:0]      raw_word;
  logic [7:0]       deg_int;
  logic             half_deg;
  logic             res_valid;
  logic             bus_err;

  temp_poll_seq #(.GAP_W(GAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .poll_gap(poll_gap),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_rd_ack(cmd_rd_ack), .rsp_done(rsp_done), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .raw_word(raw_word), .deg_int(deg_int),
    .half_deg(half_deg), .res_valid(res_valid), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder configuration
  int       latency = 0;
  int       nack_at = -1;
  logic [7:0] hi_byte = 0, lo_byte = 0;

  // responder state and log
  int  pos = 0, rd_idx = 0, lat = 0, idle = 0, exp_gap = 0;
  bit  have_stop = 0;
  int  polls_done = 0, last_len = 0;
  int  log_op [0:15];
  int  log_wd [0:15];
  int  log_ra [0:15];
  int  valid_cnt = 0, err_cnt = 0;
  bit  prev_valid = 0;

  always @(negedge clk) begin
    bit was;
    if (!rst_n) begin
      rsp_done = 0; rsp_ack = 0; rsp_rdata = 0;
      pos = 0; rd_idx = 0; lat = 0; idle = 0; have_stop = 0;
    end else begin
      was = rsp_done;
      rsp_done = 0;
      if (!cmd_valid) idle++;
      else if (!was) begin
        if (pos == 0 && have_stop) begin
          check(idle == exp_gap, "R8 gap", idle, exp_gap);
          have_stop = 0;
        end
        if (pos == 0) idle = 0;
        if (lat < latency) lat++;
        else begin
          lat = 0;
          if (pos < 16) begin
            log_op[pos] = int'(cmd_op);
            log_wd[pos] = int'(cmd_wdata);
            log_ra[pos] = int'(cmd_rd_ack);
          end
          rsp_done = 1;
          rsp_ack  = (pos != nack_at);
          if (cmd_op == 2'd2) begin
            rsp_rdata = (rd_idx == 0) ? hi_byte : lo_byte;
            rd_idx++;
          end else begin
            rsp_rdata = 8'h5A;
          end
          if (cmd_op == 2'd3) begin
            last_len  = pos + 1;
            pos       = 0;
            rd_idx    = 0;
            exp_gap   = int'(poll_gap) + 1;
            have_stop = 1;
            idle      = 0;
            polls_done++;
          end else begin
            pos++;
          end
        end
      end
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_valid) begin
        valid_cnt++;
        check(!prev_valid, "R6 pulse width", 1, 0);
      end
      if (bus_err) err_cnt++;
      prev_valid = res_valid;
    end
  end

  logic [15:0] exp_raw = 0;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  // nack_pos < 0 means a good poll
  task automatic run_poll(input int nack_pos);
    int target;
    int exp_len;
    int eop [0:7];
    int ewd [0:7];
    eop = '{0, 1, 1, 0, 1, 2, 2, 3};
    ewd = '{0, 8'h90, 8'h00, 0, 8'h91, 0, 0, 0};
    target = polls_done + 1;
    wait (polls_done == target);
    @(posedge clk); #1;
    exp_len = (nack_pos < 0) ? 8 : nack_pos + 2;
    check(last_len == exp_len, "R2 length", last_len, exp_len);
    for (int i = 0; i < exp_len && i < 8; i++) begin
      int eo;
      eo = (i == exp_len - 1) ? 3 : eop[i];
      check(log_op[i] == eo, "R2 op", log_op[i], eo);
      if (eo == 1) check(log_wd[i] == ewd[i], "R2 write byte", log_wd[i], ewd[i]);
      if (eo == 2) check(log_ra[i] == ((i == 5) ? 1 : 0), "R3 read ack", log_ra[i], (i == 5) ? 1 : 0);
    end
    if (nack_pos < 0) begin
      exp_raw = {hi_byte, lo_byte};
      check(valid_cnt == 1, "R6 valid count", valid_cnt, 1);
      check(err_cnt == 0, "R7 no err", err_cnt, 0);
    end else begin
      check(valid_cnt == 0, "R7 no valid", valid_cnt, 0);
      check(err_cnt == 1, "R7 err count", err_cnt, 1);
    end
    check(raw_word == exp_raw, "R4 raw", raw_word, exp_raw);
    check(deg_int == exp_raw[15:8], "R5 deg", deg_int, exp_raw[15:8]);
    check(half_deg == exp_raw[7], "R5 half", half_deg, exp_raw[7]);
    valid_cnt = 0;
    err_cnt   = 0;
  endtask

  initial begin
    logic [7:0] lows [0:3];
    lows = '{8'h00, 8'h80, 8'h7F, 8'hFF};
    rst_n    = 1'b0;
    poll_gap = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    check(res_valid == 0 && bus_err == 0, "R1 strobes", {res_valid, bus_err}, 0);
    check(raw_word == 0 && deg_int == 0 && half_deg == 0, "R1 results", raw_word, 0);
    @(negedge clk); rst_n = 1'b1;
    check(cmd_valid == 0 && res_valid == 0, "R1 after release", cmd_valid, 0);
    // sweep: R2 R3 R4 R5 R6 R8
    for (int h = 0; h < 256; h += 17) begin
      for (int l = 0; l < 4; l++) begin
        hi_byte  = h[7:0];
        lo_byte  = lows[l];
        latency  = (h + l) % 3;
        poll_gap = GAP_W'((h / 17 + l) % 6);
        run_poll(-1);
      end
    end
    // R7 aborts on each unacknowledged write
    for (int k = 0; k < 3; k++) begin
      int p;
      p = (k == 0) ? 1 : (k == 1) ? 2 : 4;
      nack_at = p;
      hi_byte = 8'hC3; lo_byte = 8'h11;
      run_poll(p);
      nack_at = -1;
      hi_byte = 8'h19 + 8'(k); lo_byte = 8'h80;
      run_poll(-1);
    end
    summary();
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

endmodule